// File: doc/BRIEF.md
# Execute-to-Operand Bypass Multiplexer

This block sits between the operand-fetch stage and the execute stage of a four-stage in-order pipeline. It builds the two operand buses that the operand-fetch stage hands forward. Without a bypass, an instruction that reads a register written by the instruction just ahead of it would see stale register-file data. The block compares the execute stage's destination against each operand's register address. On a match, it steers the result still in flight into the operand bus. Dependent back-to-back instructions therefore proceed without bubbles.

The in-flight result is picked before the compare. It is either the function-unit output or the data-memory read data, and the choice uses the same result-source bit that the writeback mux uses. As a result, a load followed by its consumer and an arithmetic operation followed by its consumer both receive the value that will actually be written. Operand A normally carries register data or the program counter. Operand B normally carries register data or the decoded constant. A bypass hit overrides the register path only. Register address 0 never bypasses.

Top module: `fwd_operand_mux`

## Requirements
- R1: With `a_sel_pc`=0 and no bypass hit on A, `opnd_a` equals `rf_a_data`.
- R2: With `a_sel_pc`=1, `opnd_a` equals `pc_value`, whatever the address compare gives.
- R3: With `b_sel_const`=0 and no bypass hit on B, `opnd_b` equals `rf_b_data`.
- R4: With `b_sel_const`=1, `opnd_b` equals `const_value`, whatever the address compare gives.
- R5: A bypass hit on A occurs when `a_sel_pc`=0, `ex_reg_write`=1, `ex_dest_addr`==`a_addr` and `ex_dest_addr`!=0. On a hit, `opnd_a` equals the in-flight result.
- R6: A bypass hit on B occurs when `b_sel_const`=0, `ex_reg_write`=1, `ex_dest_addr`==`b_addr` and `ex_dest_addr`!=0. On a hit, `opnd_b` equals the in-flight result.
- R7: The in-flight result is `ex_mem_rdata` when `ex_sel_mem`=1 and `ex_alu_result` when `ex_sel_mem`=0.
- R8: A destination address of 0 never produces a bypass on either operand.
- R9: With `ex_reg_write`=0, neither operand takes the in-flight result.
- R10: When A and B both hit on the same destination, both buses carry the same in-flight result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rf_a_data | input | W | Register-file read data for operand A |
| rf_b_data | input | W | Register-file read data for operand B |
| pc_value | input | W | Program-counter value offered to operand A |
| const_value | input | W | Decoded constant offered to operand B |
| ex_alu_result | input | W | Function-unit output in the execute stage |
| ex_mem_rdata | input | W | Data-memory read data in the execute stage |
| ex_sel_mem | input | 1 | Execute result source: 1 memory, 0 function unit |
| ex_dest_addr | input | AW | Destination register of the execute-stage instruction |
| ex_reg_write | input | 1 | Execute-stage instruction writes the register file |
| a_addr | input | AW | Register address read for operand A |
| b_addr | input | AW | Register address read for operand B |
| a_sel_pc | input | 1 | Operand A takes the PC instead of a register |
| b_sel_const | input | 1 | Operand B takes the constant instead of a register |
| opnd_a | output | W | Operand bus A |
| opnd_b | output | W | Operand bus B |

## Verification
The bench sweeps every combination of destination, both read addresses and the four control bits in a narrow-address configuration. That sweep covers the corner cases where a mis-built bypass goes wrong. If the zero-address guard is missing, a write to register 0 leaks into a consumer of register 0. If the hit ignores the write enable, a store or branch in execute corrupts an operand. If the PC or constant selects lose to the bypass, an immediate or PC-relative operand is replaced by an unrelated result. If the pre-selection uses the wrong source, a load's consumer receives the address computed by the function unit instead of the loaded data.

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic [W-1:0]  rf_a_data,
  input  logic [W-1:0]  rf_b_data,
  input  logic [W-1:0]  pc_value,
  input  logic [W-1:0]  const_value,
  input  logic [W-1:0]  ex_alu_result,
  input  logic [W-1:0]  ex_mem_rdata,
  input  logic          ex_sel_mem,
  input  logic [AW-1:0] ex_dest_addr,
  input  logic          ex_reg_write,
  input  logic [AW-1:0] a_addr,
  input  logic [AW-1:0] b_addr,
  input  logic          a_sel_pc,
  input  logic          b_sel_const,
  output logic [W-1:0]  opnd_a,
  output logic [W-1:0]  opnd_b
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic          dest_live;
  logic          hit_a, hit_b;
  logic [W-1:0]  ex_result;

  assign dest_live = ex_reg_write && (ex_dest_addr != ZERO_REG);
  assign ex_result = ex_sel_mem ? ex_mem_rdata : ex_alu_result;
  assign hit_a     = !a_sel_pc    && dest_live && (ex_dest_addr == a_addr);
  assign hit_b     = !b_sel_const && dest_live && (ex_dest_addr == b_addr);

  always_comb begin
    if (a_sel_pc)   opnd_a = pc_value;
    else if (hit_a) opnd_a = ex_result;
    else            opnd_a = rf_a_data;
  end

  always_comb begin
    if (b_sel_const) opnd_b = const_value;
    else if (hit_b)  opnd_b = ex_result;
    else             opnd_b = rf_b_data;
  end

  always_comb begin
    if (!$isunknown({a_sel_pc, b_sel_const, ex_reg_write, ex_dest_addr, ex_sel_mem,
                     pc_value, const_value, ex_mem_rdata, ex_alu_result})) begin
      if (a_sel_pc)
        assert_pc_path_R2: assert (opnd_a == pc_value);
      if (b_sel_const)
        assert_const_path_R4: assert (opnd_b == const_value);
      if (!a_sel_pc && (ex_dest_addr == ZERO_REG || !ex_reg_write))
        assert_no_fwd_a_R8_R9: assert (opnd_a == rf_a_data);
      if (!b_sel_const && (ex_dest_addr == ZERO_REG || !ex_reg_write))
        assert_no_fwd_b_R8_R9: assert (opnd_b == rf_b_data);
      if (hit_a && ex_sel_mem)
        assert_load_fwd_R7: assert (opnd_a == ex_mem_rdata);
      if (hit_a && hit_b)
        assert_same_fwd_R10: assert (opnd_a == opnd_b);
    end
  end
endmodule

// File: tb/test_fwd_operand_mux.sv
module test_fwd_operand_mux;
  localparam int W  = 32;
  localparam int AW = 3;
  localparam int NR = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0]  rf_a_data, rf_b_data, pc_value, const_value, ex_alu_result, ex_mem_rdata;
  logic          ex_sel_mem, ex_reg_write, a_sel_pc, b_sel_const;
  logic [AW-1:0] ex_dest_addr, a_addr, b_addr;
  logic [W-1:0]  opnd_a, opnd_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  fwd_operand_mux #(.W(W), .AW(AW)) i_fwd_operand_mux (
    .rf_a_data(rf_a_data), .rf_b_data(rf_b_data), .pc_value(pc_value),
    .const_value(const_value), .ex_alu_result(ex_alu_result), .ex_mem_rdata(ex_mem_rdata),
    .ex_sel_mem(ex_sel_mem), .ex_dest_addr(ex_dest_addr), .ex_reg_write(ex_reg_write),
    .a_addr(a_addr), .b_addr(b_addr), .a_sel_pc(a_sel_pc), .b_sel_const(b_sel_const),
    .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (dest=%0d a=%0d b=%0d we=%b mem=%b pc=%b k=%b)",
               tag, act, exp, ex_dest_addr, a_addr, b_addr, ex_reg_write, ex_sel_mem,
               a_sel_pc, b_sel_const);
    end
  endtask

  initial begin
    rf_a_data = '0; rf_b_data = '0; pc_value = '0; const_value = '0;
    ex_alu_result = '0; ex_mem_rdata = '0; ex_sel_mem = 0; ex_reg_write = 0;
    a_sel_pc = 0; b_sel_const = 0; ex_dest_addr = '0; a_addr = '0; b_addr = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 idle", opnd_a, '0);
    chk("R3 idle", opnd_b, '0);

    for (int d = 0; d < NR; d++)
      for (int a = 0; a < NR; a++)
        for (int b = 0; b < NR; b++)
          for (int c = 0; c < 16; c++) begin
            int n;
            logic [W-1:0] res, ea, eb;
            logic ha, hb;
            string ta, tb;
            n = ((d * NR + a) * NR + b) * 16 + c;
            @(negedge clk);
            ex_dest_addr  = AW'(d);
            a_addr        = AW'(a);
            b_addr        = AW'(b);
            ex_reg_write  = c[0];
            ex_sel_mem    = c[1];
            a_sel_pc      = c[2];
            b_sel_const   = c[3];
            rf_a_data     = 32'h1000_0000 + n;
            rf_b_data     = 32'h2000_0000 + n;
            pc_value      = 32'h3000_0000 + n;
            const_value   = 32'h4000_0000 + n;
            ex_alu_result = 32'h5000_0000 + n;
            ex_mem_rdata  = 32'h6000_0000 + n;
            res = c[1] ? ex_mem_rdata : ex_alu_result;
            ha  = !c[2] && c[0] && d != 0 && d == a;
            hb  = !c[3] && c[0] && d != 0 && d == b;
            ea  = c[2] ? pc_value : (ha ? res : rf_a_data);
            eb  = c[3] ? const_value : (hb ? res : rf_b_data);
            if (c[2])                      ta = "R2";
            else if (ha)                   ta = c[1] ? "R7 A" : "R5";
            else if (d == 0 && a == 0 && c[0]) ta = "R8 A";
            else if (!c[0] && d == a)      ta = "R9 A";
            else                           ta = "R1";
            if (c[3])                      tb = "R4";
            else if (hb)                   tb = c[1] ? "R7 B" : "R6";
            else if (d == 0 && b == 0 && c[0]) tb = "R8 B";
            else if (!c[0] && d == b)      tb = "R9 B";
            else                           tb = "R3";
            #2;
            chk(ta, opnd_a, ea);
            chk(tb, opnd_b, eb);
            if (ha && hb) chk("R10", opnd_b, opnd_a);
          end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule